// File: doc/BRIEF.md
# Processor clock, reset and ready conditioner

This block runs entirely on a fast oscillator clock and derives three signals for a processor. The processor clock is the oscillator divided by three. It is high for one oscillator period and low for the next two, which gives a one-third duty cycle. The block also takes an asynchronous, active-low reset request. It asserts the processor reset at once and releases it only after a synchronized and stretched interval, so the processor always sees more than four full clock periods of reset. Finally it merges a set of device ready lines into one ready output. Each ready line has its own active-low enable. The merged value is retimed to rising edges of the processor clock.

While the reset request is active, the divider is held, so the processor clock sits low. The divider resumes only after the request has passed a two-flop synchronizer. Every output is a register on the oscillator clock, so no output has a combinational path from an input.

Top module: `clk_rst_rdy_cond`

## Requirements
- R1: Once running, `clk_o` repeats a three-oscillator-cycle period: high for exactly one `osc_clk_i` cycle, then low for exactly two.
- R2: While `rst_ni` is low, `reset_o` is 1 and both `clk_o` and `rdy_o` are 0, from the moment `rst_ni` falls and whatever the ready inputs do.
- R3: After `rst_ni` rises, the first high phase of `clk_o` begins at the 5th rising edge of `osc_clk_i`: two edges in the synchronizer, then three divider steps.
- R4: After `rst_ni` rises, `reset_o` falls on the same oscillator edge as the 6th rise of `clk_o`. It therefore stays high through five full `clk_o` periods.
- R5: `rdy_o` carries the OR over all lines k of (`rdy_i[k]` AND NOT `rdy_en_ni[k]`). A line whose enable is 1 is ignored.
- R6: `rdy_o` changes only on oscillator edges where `clk_o` rises. A merged value that is stable across one `clk_o` rise appears on `rdy_o` at the next `clk_o` rise, and not earlier.
- R7: Once `reset_o` has fallen, it stays 0 until `rst_ni` goes low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Oscillator clock, three times the processor clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset request |
| rdy_i | input | NUM_RDY (2) | Device ready lines, active high |
| rdy_en_ni | input | NUM_RDY (2) | Per-line enables, active low |
| clk_o | output | 1 | Processor clock with one-third duty cycle |
| reset_o | output | 1 | Processor reset, active high, stretched |
| rdy_o | output | 1 | Merged ready, retimed to rising edges of `clk_o` |

## Verification
The bench samples on falling oscillator edges and counts oscillator edges and `clk_o` rises from each stimulus. After the request is released, it expects the first `clk_o` high sample on the 5th edge and the `reset_o` fall on the sample of the 6th `clk_o` rise. Ready inputs are changed just after a `clk_o` rise. The bench then expects the old `rdy_o` at the next rise and the new value at the rise after that, six oscillator cycles in all. Duty-cycle checks measure every completed high run and low run. Reset assertion is checked one nanosecond after the request falls, in the middle of an oscillator cycle.

// File: rtl/cond_pkg.sv
package cond_pkg;
  localparam int unsigned DIV_RATIO_DEF = 3;
  localparam int unsigned HIGH_CYC_DEF  = 1;
  localparam int unsigned RST_CLKS_DEF  = 5;
  localparam int unsigned NUM_RDY_DEF   = 2;
  localparam int unsigned SYNC_DEPTH    = 2;
  localparam int unsigned RDY_STAGES    = 2;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned DEPTH = cond_pkg::SYNC_DEPTH
) (
  input  logic osc_clk_i,
  input  logic rst_ni,
  output logic run_o
);
  logic [DEPTH-1:0] sync_q;

  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[DEPTH-2:0], 1'b1};
  end

  assign run_o = sync_q[DEPTH-1];

  // R3
  sync_mono_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    run_o |=> run_o);
endmodule

// File: rtl/clk_div.sv
module clk_div #(
  parameter int unsigned DIV_RATIO = cond_pkg::DIV_RATIO_DEF,
  parameter int unsigned HIGH_CYC  = cond_pkg::HIGH_CYC_DEF
) (
  input  logic osc_clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic clk_o,
  output logic rise_o
);
  localparam int unsigned CW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          clk_q;

  assign cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  // high phase begins on the wrap to state 0
  assign rise_o  = run_i && (cnt_q == LAST);

  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (run_i) begin
      cnt_q <= cnt_nxt;
      clk_q <= (cnt_nxt < CW'(HIGH_CYC));
    end
  end

  assign clk_o = clk_q;

  // R1
  cnt_range_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  generate
    if (HIGH_CYC == 1) begin : g_hi1
      // R1
      clk_hi_one_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
        clk_q |=> !clk_q);
    end
    if (DIV_RATIO - HIGH_CYC >= 2) begin : g_lo2
      // R1
      clk_lo_two_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
        $fell(clk_q) |=> !clk_q);
    end
  endgenerate

  // R3
  clk_idle_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    !run_i |-> !clk_q);
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int unsigned RST_CLKS = cond_pkg::RST_CLKS_DEF
) (
  input  logic osc_clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  output logic reset_o
);
  localparam int unsigned RCW = $clog2(RST_CLKS + 1);

  logic [RCW-1:0] cnt_q;
  logic           reset_q;

  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reset_q <= 1'b1;
      cnt_q   <= '0;
    end else if (reset_q && rise_i) begin
      // release on the rise after RST_CLKS counted rises
      if (cnt_q == RCW'(RST_CLKS)) reset_q <= 1'b0;
      else                         cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign reset_o = reset_q;

  // R4
  rst_rel_on_rise_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    $fell(reset_q) |-> $past(rise_i));

  // R7
  rst_stay_low_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    !reset_q |=> !reset_q);
endmodule

// File: rtl/rdy_sync.sv
module rdy_sync #(
  parameter int unsigned NUM_RDY = cond_pkg::NUM_RDY_DEF,
  parameter int unsigned STAGES  = cond_pkg::RDY_STAGES
) (
  input  logic               osc_clk_i,
  input  logic               rst_ni,
  input  logic               rise_i,
  input  logic [NUM_RDY-1:0] rdy_i,
  input  logic [NUM_RDY-1:0] rdy_en_ni,
  output logic               rdy_o
);
  logic              merged;
  logic [STAGES-1:0] stg_q;

  assign merged = |(rdy_i & ~rdy_en_ni);

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stg
      logic d;
      if (s == 0) begin : g_first
        assign d = merged;
      end else begin : g_next
        assign d = stg_q[s-1];
      end
      always_ff @(posedge osc_clk_i or negedge rst_ni) begin
        if (!rst_ni)     stg_q[s] <= 1'b0;
        else if (rise_i) stg_q[s] <= d;
      end
    end
  endgenerate

  assign rdy_o = stg_q[STAGES-1];

  // R6
  rdy_on_rise_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    !$stable(rdy_o) |-> $past(rise_i));

  // R6
  rdy_hold_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    !rise_i |=> $stable(stg_q));
endmodule

// File: rtl/clk_rst_rdy_cond.sv
module clk_rst_rdy_cond #(
  parameter int unsigned DIV_RATIO = cond_pkg::DIV_RATIO_DEF,
  parameter int unsigned HIGH_CYC  = cond_pkg::HIGH_CYC_DEF,
  parameter int unsigned RST_CLKS  = cond_pkg::RST_CLKS_DEF,
  parameter int unsigned NUM_RDY   = cond_pkg::NUM_RDY_DEF
) (
  input  logic               osc_clk_i,
  input  logic               rst_ni,
  input  logic [NUM_RDY-1:0] rdy_i,
  input  logic [NUM_RDY-1:0] rdy_en_ni,
  output logic               clk_o,
  output logic               reset_o,
  output logic               rdy_o
);
  logic run;
  logic rise;

  rst_sync #(.DEPTH(cond_pkg::SYNC_DEPTH)) u_sync (
    .osc_clk_i(osc_clk_i),
    .rst_ni   (rst_ni),
    .run_o    (run)
  );

  clk_div #(.DIV_RATIO(DIV_RATIO), .HIGH_CYC(HIGH_CYC)) u_div (
    .osc_clk_i(osc_clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .clk_o    (clk_o),
    .rise_o   (rise)
  );

  rst_stretch #(.RST_CLKS(RST_CLKS)) u_rst (
    .osc_clk_i(osc_clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rise),
    .reset_o  (reset_o)
  );

  rdy_sync #(.NUM_RDY(NUM_RDY), .STAGES(cond_pkg::RDY_STAGES)) u_rdy (
    .osc_clk_i(osc_clk_i),
    .rst_ni   (rst_ni),
    .rise_i   (rise),
    .rdy_i    (rdy_i),
    .rdy_en_ni(rdy_en_ni),
    .rdy_o    (rdy_o)
  );

  // R2
  rdy_in_reset_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    (reset_o && !clk_o && !run) |-> !rdy_o);

  // R4
  rst_while_clk_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    !run |-> reset_o);
endmodule

// File: tb/clk_rst_rdy_cond_tb.sv
module clk_rst_rdy_cond_tb;
  localparam int NR = 2;

  logic          osc_clk = 1'b0;
  logic          rst_n   = 1'b0;
  logic [NR-1:0] rdy     = '0;
  logic [NR-1:0] en_n    = '1;
  logic          clk_w, reset_w, rdy_w;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  always #5 osc_clk = ~osc_clk;

  clk_rst_rdy_cond u_dut (
    .osc_clk_i(osc_clk),
    .rst_ni   (rst_n),
    .rdy_i    (rdy),
    .rdy_en_ni(en_n),
    .clk_o    (clk_w),
    .reset_o  (reset_w),
    .rdy_o    (rdy_w)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    do @(negedge osc_clk); while (clk_w !== 1'b1);
  endtask

  task automatic release_and_check();
    int edges;
    int rises;
    int early_drop;
    edges = 0;
    early_drop = 0;
    @(negedge osc_clk);
    rst_n = 1'b1;
    do begin
      @(negedge osc_clk);
      edges++;
      if (reset_w !== 1'b1) early_drop = 1;
    end while (clk_w !== 1'b1 && edges < 40);
    chk("R3 first clk high edge", edges, 5);
    rises = 1;
    while (reset_w === 1'b1 && rises < 20) begin
      @(negedge osc_clk);
      if (clk_w === 1'b1) rises++;
    end
    chk("R4 reset drop rise index", rises, 6);
    chk("R4 reset drop on clk high", int'(clk_w), 1);
    chk("R4 reset high before first rise", early_drop, 0);
  endtask

  initial begin
    int exp_r, prev_r, run_len, prev_clk, first, stuck;
    // R2: reset held, ready lines active and enabled
    rdy  = 2'b11;
    en_n = 2'b00;
    repeat (6) @(negedge osc_clk);
    chk("R2 reset_o in reset", int'(reset_w), 1);
    chk("R2 clk_o in reset", int'(clk_w), 0);
    chk("R2 rdy_o in reset", int'(rdy_w), 0);
    rdy  = '0;
    en_n = '1;
    release_and_check();

    // R1: measure every completed run
    prev_clk = int'(clk_w);
    run_len  = 1;
    first    = 1;
    for (int i = 0; i < 45; i++) begin
      @(negedge osc_clk);
      if (int'(clk_w) == prev_clk) run_len++;
      else begin
        if (!first) chk(prev_clk ? "R1 high width" : "R1 low width", run_len, prev_clk ? 1 : 2);
        first    = 0;
        prev_clk = int'(clk_w);
        run_len  = 1;
      end
    end

    // R5/R6: sweep all ready and enable combinations
    wait_rise();
    rdy = '0; en_n = '1;
    wait_rise();
    wait_rise();
    prev_r = 0;
    chk("R6 ready idle", int'(rdy_w), 0);
    for (int c = 0; c < 16; c++) begin
      rdy   = c[1:0];
      en_n  = c[3:2];
      exp_r = int'(|(rdy & ~en_n));
      wait_rise();
      chk("R6 ready not before second rise", int'(rdy_w), prev_r);
      @(negedge osc_clk);
      chk("R6 ready held between rises", int'(rdy_w), prev_r);
      wait_rise();
      chk("R5 merged ready value", int'(rdy_w), exp_r);
      prev_r = exp_r;
    end

    // R2: request mid-cycle, asserts without an edge
    @(negedge osc_clk);
    #2 rst_n = 1'b0;
    #1;
    chk("R2 async reset_o", int'(reset_w), 1);
    chk("R2 async clk_o", int'(clk_w), 0);
    chk("R2 async rdy_o", int'(rdy_w), 0);
    rdy = 2'b01; en_n = 2'b10;
    repeat (4) @(negedge osc_clk);
    chk("R2 rdy_o held in reset", int'(rdy_w), 0);
    chk("R2 clk_o held in reset", int'(clk_w), 0);
    rdy = '0; en_n = '1;
    release_and_check();

    // R7: reset stays released
    stuck = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge osc_clk);
      if (reset_w !== 1'b0) stuck = 1;
    end
    chk("R7 reset stays low", stuck, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule